// File: doc/BRIEF.md
# Machine Trap Vector Register and Target Generator

This block holds the machine-level trap vector control register and turns it into the address the core jumps to when a trap is taken. Software reaches the register through a control-register access port. The port carries an address, a privilege level, an operation code and write data, and returns read data. A write, set-bits or clear-bits operation forms a candidate value. That value then goes through per-field legalization before it is stored.

The register has two fields. The upper field is a base address with word granularity, and it accepts any value written to it. The lowest two bits select the dispatch mode. Only two codes are legal: direct and vectored. A write that carries any other code leaves the stored mode as it was. The trap side takes an interrupt flag and a cause number. It returns the target address in the same cycle. In direct mode every trap lands on the base. In vectored mode an interrupt lands on the base plus four times its cause number, and a synchronous exception still lands on the base.

Top module: `tvec_unit`

## Requirements
- R1: After reset the register reads back as zero (base 0, mode 0 = direct), and the trap target is 0.
- R2: The port is selected only when the address equals 0x305 and the privilege input equals 3 (machine level). `csr_hit` is 1 exactly then. While the port is not selected, `csr_rdata` is 0.
- R3: With `csr_op` = 1 (write) on a selected access, bits 63:2 of the register take `csr_wdata[63:2]` at the next clock edge.
- R4: Mode codes 0 (direct) and 1 (vectored), found in bits 1:0 of the candidate value, are stored as given.
- R5: Mode codes 2 and 3 in the candidate value leave bits 1:0 unchanged, and the base field is still updated. Bits 1:0 always read back 0 or 1.
- R6: With `csr_op` = 2 (set bits), the candidate value is the current value OR `csr_wdata`, legalized as in R4/R5.
- R7: With `csr_op` = 3 (clear bits), the candidate value is the current value AND NOT `csr_wdata`, legalized as in R4/R5.
- R8: `csr_op` = 0, or any operation on an access that is not selected, leaves the register unchanged.
- R9: In direct mode, `trap_target` = base × 4 for interrupts and for exceptions alike.
- R10: In vectored mode with `trap_is_irq` = 1, `trap_target` = base × 4 + `trap_cause` × 4, modulo 2^64.
- R11: In vectored mode with `trap_is_irq` = 0, `trap_target` = base × 4.
- R12: `trap_target` follows the trap inputs and the stored register in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 12 | Control-register address |
| csr_priv | input | 2 | Privilege level of the access (3 = machine) |
| csr_op | input | 2 | 0 none, 1 write, 2 set bits, 3 clear bits |
| csr_wdata | input | 64 | Write data or bit mask |
| csr_rdata | output | 64 | Register value when selected, else 0 |
| csr_hit | output | 1 | Access selects this register |
| trap_is_irq | input | 1 | 1 = asynchronous interrupt, 0 = synchronous exception |
| trap_cause | input | 6 | Cause number without the interrupt flag |
| trap_target | output | 64 | Address to jump to |

## Verification
The hardest case to reach is a set-bits or clear-bits operation whose combined low bits form an illegal mode code. An example is a set of bit 1 while the register is in vectored mode. To hit this case the candidate value has to come from the stored state and not from the write data alone. The bench therefore first loads every legal starting mode with a plain write. It then applies all three operations with all four low-bit patterns and predicts the result arithmetically. The vectored offset is swept over every cause number with both trap kinds. This includes a base of all ones, so the wrap-around of the address sum is exercised.

// File: rtl/tvec_pkg.sv
`timescale 1ns/1ps
package tvec_pkg;
    localparam int XLEN    = 64;
    localparam int BASE_W  = XLEN - 2;
    localparam int ADDR_W  = 12;
    localparam int PRIV_W  = 2;
    localparam logic [PRIV_W-1:0] PRIV_MACHINE = 2'b11;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } tvec_op_e;

    // Stored state: word-aligned base and one flag for vectored dispatch.
    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic              vec;
    } tvec_state_t;

    function automatic logic [XLEN-1:0] tvec_pack(input tvec_state_t s);
        return {s.base, 1'b0, s.vec};
    endfunction
endpackage

// File: rtl/tvec_decode.sv
`timescale 1ns/1ps
module tvec_decode
    import tvec_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SEL_ADDR = 12'h305
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [PRIV_W-1:0] priv,
    output logic              hit
);
    logic addr_match;
    logic priv_ok;

    always_comb begin
        addr_match = (addr == SEL_ADDR);
        priv_ok    = (priv == PRIV_MACHINE);
        hit        = addr_match && priv_ok;
    end
endmodule

// File: rtl/tvec_legalize.sv
`timescale 1ns/1ps
module tvec_legalize
    import tvec_pkg::*;
(
    input  tvec_state_t     cur,
    input  tvec_op_e        op,
    input  logic [XLEN-1:0] wdata,
    output tvec_state_t     nxt
);
    logic [XLEN-1:0] cur_word;
    logic [XLEN-1:0] cand;
    logic            mode_legal;

    always_comb begin
        cur_word = tvec_pack(cur);
        unique case (op)
            OP_WRITE: cand = wdata;
            OP_SET:   cand = cur_word | wdata;
            OP_CLEAR: cand = cur_word & ~wdata;
            default:  cand = cur_word;
        endcase
        // Only codes 0 and 1 are legal; anything else keeps the old mode.
        mode_legal = (cand[1] == 1'b0);
        nxt.base   = cand[XLEN-1:2];
        nxt.vec    = mode_legal ? cand[0] : cur.vec;
    end
endmodule

// File: rtl/tvec_target.sv
`timescale 1ns/1ps
module tvec_target
    import tvec_pkg::*;
#(
    parameter int CAUSE_W = 6
) (
    input  tvec_state_t        st,
    input  logic               is_irq,
    input  logic [CAUSE_W-1:0] cause,
    output logic [XLEN-1:0]    target
);
    localparam int PAD_W = XLEN - CAUSE_W - 2;

    logic [XLEN-1:0] base_addr;
    logic [XLEN-1:0] offset;
    logic            use_offset;

    always_comb begin
        base_addr  = {st.base, 2'b00};
        offset     = {{PAD_W{1'b0}}, cause, 2'b00};
        use_offset = st.vec && is_irq;
        target     = use_offset ? (base_addr + offset) : base_addr;
    end
endmodule

// File: rtl/tvec_unit.sv
`timescale 1ns/1ps
module tvec_unit
    import tvec_pkg::*;
#(
    parameter logic [11:0] SEL_ADDR = 12'h305,
    parameter int          CAUSE_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [11:0]        csr_addr,
    input  logic [1:0]         csr_priv,
    input  logic [1:0]         csr_op,
    input  logic [63:0]        csr_wdata,
    output logic [63:0]        csr_rdata,
    output logic               csr_hit,
    input  logic               trap_is_irq,
    input  logic [CAUSE_W-1:0] trap_cause,
    output logic [63:0]        trap_target
);
    tvec_state_t state_d, state_q;
    tvec_state_t legal_nxt;
    tvec_op_e    op;
    logic        hit;

    assign op = tvec_op_e'(csr_op);

    tvec_decode #(.SEL_ADDR(SEL_ADDR)) u_decode (
        .addr (csr_addr),
        .priv (csr_priv),
        .hit  (hit)
    );

    tvec_legalize u_legal (
        .cur   (state_q),
        .op    (op),
        .wdata (csr_wdata),
        .nxt   (legal_nxt)
    );

    tvec_target #(.CAUSE_W(CAUSE_W)) u_target (
        .st     (state_q),
        .is_irq (trap_is_irq),
        .cause  (trap_cause),
        .target (trap_target)
    );

    always_comb begin
        state_d = state_q;
        if (hit && (op != OP_NONE)) begin
            state_d = legal_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        csr_hit   = hit;
        csr_rdata = hit ? tvec_pack(state_q) : '0;
    end

    AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_hit |-> (csr_rdata == '0)); // R2

    AST_WRITE_TAKES_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_hit && csr_op == 2'd1) |=> (state_q.base == $past(csr_wdata[63:2]))); // R3

    AST_ILLEGAL_MODE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_hit && csr_op == 2'd1 && csr_wdata[1]) |=> (state_q.vec == $past(state_q.vec))); // R5

    AST_MISS_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!csr_hit || csr_op == 2'd0) |=> $stable(state_q)); // R8

    AST_DIRECT_TO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        !state_q.vec |-> (trap_target == {state_q.base, 2'b00})); // R9

    AST_EXC_TO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_is_irq |-> (trap_target == {state_q.base, 2'b00})); // R11

    AST_IRQ_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.vec && trap_is_irq) |->
            ((trap_target - {state_q.base, 2'b00}) == {{(64-CAUSE_W-2){1'b0}}, trap_cause, 2'b00})); // R10
endmodule

// File: tb/sim_tvec_unit.sv
`timescale 1ns/1ps
module sim_tvec_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] csr_addr = 12'h305;
    logic [1:0]  csr_priv = 2'd3;
    logic [1:0]  csr_op = 2'd0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;
    logic        csr_hit;
    logic        trap_is_irq = 1'b0;
    logic [5:0]  trap_cause = '0;
    logic [63:0] trap_target;

    int vectors = 0;
    int fails = 0;
    bit done = 0;
    logic [63:0] mdl = '0;

    always #10 clk = ~clk;

    tvec_unit u0 (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_priv(csr_priv),
        .csr_op(csr_op), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .csr_hit(csr_hit), .trap_is_irq(trap_is_irq), .trap_cause(trap_cause),
        .trap_target(trap_target)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] predict(input logic [63:0] cur, input int op, input logic [63:0] wd);
        logic [63:0] cand;
        logic [63:0] res;
        case (op)
            1: cand = wd;
            2: cand = cur | wd;
            3: cand = cur & ~wd;
            default: cand = cur;
        endcase
        res = {cand[63:2], 2'b00};
        res[1:0] = (cand[1:0] < 2) ? cand[1:0] : cur[1:0];
        return res;
    endfunction

    task automatic access(input logic [11:0] a, input logic [1:0] p, input int op, input logic [63:0] wd);
        @(negedge clk);
        csr_addr = a; csr_priv = p; csr_op = op[1:0]; csr_wdata = wd;
        if (a == 12'h305 && p == 2'd3) mdl = predict(mdl, op, wd);
        @(posedge clk);
        @(negedge clk);
        csr_addr = 12'h305; csr_priv = 2'd3; csr_op = 2'd0; csr_wdata = '0;
        #2;
    endtask

    function automatic logic [63:0] exp_target(input logic [63:0] r, input bit irq, input int c);
        logic [63:0] b;
        b = {r[63:2], 2'b00};
        if (r[0] && irq) return b + 64'(c * 4);
        return b;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        check("R1 reset readback", csr_rdata, 64'd0);
        check("R1 reset target", trap_target, 64'd0);
        check("R2 hit asserted", {63'd0, csr_hit}, 64'd1);

        // Write/set/clear sweep over start modes and low-bit patterns
        for (int sm = 0; sm < 2; sm++) begin
            for (int op = 1; op < 4; op++) begin
                for (int lo = 0; lo < 4; lo++) begin
                    logic [63:0] pa, pb;
                    pa = 64'hA5C3_0F96_1E2D_3C48 ^ (64'(sm * 7 + op * 13 + lo) << 9);
                    pb = 64'h5F0A_C3E1_9B27_6D14 ^ (64'(op * 31 + lo) << 20);
                    access(12'h305, 2'd3, 1, {pa[63:2], 2'(sm)});
                    check("R4 legal mode load", csr_rdata, mdl);
                    access(12'h305, 2'd3, op, {pb[63:2], 2'(lo)});
                    if (op == 1)      check("R3 R5 write", csr_rdata, mdl);
                    else if (op == 2) check("R6 set bits", csr_rdata, mdl);
                    else              check("R7 clear bits", csr_rdata, mdl);
                    check("R5 mode stays legal", {62'd0, csr_rdata[1:0]} < 2 ? 64'd1 : 64'd0, 64'd1);
                end
            end
        end

        // Ignored accesses
        access(12'h305, 2'd3, 1, 64'h0123_4567_89AB_CDE1);
        for (int p = 0; p < 3; p++) begin
            for (int op = 1; op < 4; op++) begin
                @(negedge clk);
                csr_priv = 2'(p); csr_op = 2'(op); csr_wdata = 64'hFFFF_0000_FFFF_0002;
                #2;
                check("R2 miss rdata zero", csr_rdata, 64'd0);
                check("R2 miss hit low", {63'd0, csr_hit}, 64'd0);
                @(posedge clk);
                @(negedge clk);
                csr_priv = 2'd3; csr_op = 2'd0; #2;
                check("R8 low privilege ignored", csr_rdata, mdl);
            end
        end
        for (int k = 0; k < 4; k++) begin
            logic [11:0] wa;
            wa = 12'h305 ^ (12'h1 << (k * 3));
            access(wa, 2'd3, 1, 64'hDEAD_BEEF_0000_0000);
            check("R8 other address ignored", csr_rdata, mdl);
        end
        access(12'h305, 2'd3, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R8 op none ignored", csr_rdata, mdl);

        // Target sweep
        for (int bi = 0; bi < 3; bi++) begin
            for (int m = 0; m < 2; m++) begin
                logic [63:0] bv;
                bv = (bi == 0) ? 64'h0000_0000_8000_0100 :
                     (bi == 1) ? 64'hFFFF_FFFF_FFFF_FFFC : 64'h1234_5678_9ABC_DEF0;
                access(12'h305, 2'd3, 1, {bv[63:2], 2'(m)});
                for (int irq = 0; irq < 2; irq++) begin
                    for (int c = 0; c < 64; c++) begin
                        @(negedge clk);
                        trap_is_irq = irq[0]; trap_cause = 6'(c);
                        #2;
                        if (m == 0)        check("R9 direct target", trap_target, exp_target(mdl, irq[0], c));
                        else if (irq == 1) check("R10 R12 vectored irq", trap_target, exp_target(mdl, 1'b1, c));
                        else               check("R11 vectored exception", trap_target, exp_target(mdl, 1'b0, c));
                    end
                end
            end
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule